// File: doc/BRIEF.md
# Effective Address Sequencer for a 16-bit Banked Processor

This block turns one addressing-mode code and its operand bytes into the 24-bit effective address that a 16-bit accumulator/index processor with 8-bit bank registers would use. The processor registers it needs (X, Y, the direct-page base D, the stack pointer S, the already-advanced program counter, the data bank and the program bank) and the emulation and index-width flags arrive as inputs. They are captured when `start` is seen in the idle state.

Modes that go through memory fetch their 2-byte or 3-byte pointer one byte at a time on a simple request/valid read port with one cycle of latency. When the address is known the block raises `done` for one cycle. In that cycle it also presents the count of extra internal cycles the mode costs and the open-bus byte, which holds the last pointer byte read.

Top module: `eff_addr_seq`

## Requirements
- R1: Mode 0 (direct) gives {00, (D + op0) mod 2^16}, where op0 is `opnd[7:0]`. It costs 1 extra cycle when D[7:0] is nonzero and 0 otherwise. This D-low charge is added to every mode from 0 to 7.
- R2: Modes 1 and 2 (direct indexed by X or by Y). If emulation is set and D[7:0] is zero, only the low byte of the direct address is indexed and the page byte is kept. Otherwise the full 16-bit index is added mod 2^16 in bank 0. Both modes add 1 extra cycle.
- R3: Modes 3 and 4 (direct indirect, and direct indexed by X then indirect) fetch a 2-byte pointer low byte first. The pointer sits at the mode 0 or mode 1 address. The second byte address wraps within the 256-byte page when emulation is set and D[7:0] is zero, and wraps within bank 0 otherwise. The result is {DB, pointer}. Mode 4 adds 1 extra cycle.
- R4: Mode 5 (direct indirect indexed by Y) fetches the pointer as in mode 3 and gives ({DB, pointer} + Y) mod 2^24. It adds 1 extra cycle when the access is a write, or the index is 16 bits wide (`idx8`=0), or pointer[7:0] + Y[7:0] >= 0x100.
- R5: Mode 8 gives {DB, op16}, where op16 is `opnd[15:0]`. Modes 9 and 10 add X or Y to that mod 2^24. Modes 9 and 10 apply the extra-cycle rule of R4, using op16[7:0] and the low index byte.
- R6: Mode 11 fetches a 2-byte pointer from bank 0 at op16, wrapping in bank 0. Mode 12 fetches it from {PB, (op16 + X) mod 2^16}, wrapping in the program bank. Both give {PB, pointer}. Mode 12 costs 1 extra cycle and mode 11 costs none.
- R7: Modes 6 and 7 fetch a 3-byte pointer (low, high, bank) from bank 0 at the mode 0 address, wrapping in bank 0. Mode 13 does the same at op16. Modes 6 and 13 give the pointer. Mode 7 gives (pointer + Y) mod 2^24.
- R8: Mode 14 gives {00, (S + op0) mod 2^16} with 1 extra cycle. Mode 15 fetches a 2-byte pointer there, wrapping in bank 0, and gives ({DB, pointer} + Y) mod 2^24 with 2 extra cycles.
- R9: Mode 16 gives `opnd` unchanged. Mode 17 gives (`opnd` + X) mod 2^24. Neither fetches or adds extra cycles.
- R10: Mode 18 gives {PB, (PC + sign-extended op0) mod 2^16}. Mode 19 gives {PB, (PC + op16) mod 2^16}. Neither adds extra cycles.
- R11: On a read (`is_write`=0), `open_bus` takes every fetched pointer byte, so at `done` it shows the high byte of a 2-byte pointer or the bank byte of a 3-byte pointer. On a write, or in a mode that does not fetch, it keeps its earlier value.
- R12: Each pointer byte is one single-cycle `mem_req`. The next request waits for `mem_valid`. `done` is high for exactly one cycle after the last byte. A `start` seen while busy is ignored, and the register inputs are taken only when the run starts.
- R13: After reset `done` and `mem_req` are low and `open_bus` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one address computation (taken only when idle) |
| mode | input | 5 | Addressing-mode code, 0 to 19 |
| opnd | input | 24 | Operand bytes: op0 in [7:0], op16 in [15:0], long in [23:0] |
| is_write | input | 1 | Access at the final address is a write |
| emu | input | 1 | Emulation mode flag |
| idx8 | input | 1 | Index registers are 8 bits wide |
| reg_x | input | 16 | X index register |
| reg_y | input | 16 | Y index register |
| reg_d | input | 16 | Direct-page base register |
| reg_s | input | 16 | Stack pointer |
| reg_pc | input | 16 | Program counter after the operand |
| reg_db | input | 8 | Data bank |
| reg_pb | input | 8 | Program bank |
| mem_req | output | 1 | One-byte read request |
| mem_addr | output | 24 | Read address |
| mem_valid | input | 1 | Read data valid, one cycle after the request |
| mem_rdata | input | 8 | Read data |
| done | output | 1 | Result valid for this cycle |
| ea | output | 24 | Effective address |
| extra_cyc | output | 2 | Extra internal cycles charged |
| open_bus | output | 8 | Last fetched pointer byte |

## Verification
Every mode code runs against eight register and operand sets. These are crossed with emulation on and off, 8-bit and 16-bit index width, and read and write. Some sets put D[7:0] at zero and some at nonzero, which shows page wrap apart from bank-0 wrap in direct indexing and in the pointer fetch. Operand and base values of 0xFF, 0xFFFF and 0xFFFFFF, together with index values of 0x00FF and 0xFFFF, show the carry into the page byte, the wrap at the bank edge, negative branch offsets and the page-cross penalty apart from the plain case. A second `start` with scrambled inputs during each run shows that the inputs were captured at the start. Read against write shows whether the open-bus byte was held.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int BANK_W = 8;
    localparam int WORD_W = 16;
    localparam int ADDR_W = BANK_W + WORD_W;
    localparam int PEN_W  = 2;
    localparam int PTR_MAX = 3;
    localparam int BIDX_W = $clog2(PTR_MAX + 1);

    typedef enum logic [4:0] {
        AM_DP         = 5'd0,
        AM_DP_X       = 5'd1,
        AM_DP_Y       = 5'd2,
        AM_DP_IND     = 5'd3,
        AM_DP_X_IND   = 5'd4,
        AM_DP_IND_Y   = 5'd5,
        AM_DP_LONG    = 5'd6,
        AM_DP_LONG_Y  = 5'd7,
        AM_ABS        = 5'd8,
        AM_ABS_X      = 5'd9,
        AM_ABS_Y      = 5'd10,
        AM_ABS_IND    = 5'd11,
        AM_ABS_X_IND  = 5'd12,
        AM_ABS_LIND   = 5'd13,
        AM_SR         = 5'd14,
        AM_SR_IND_Y   = 5'd15,
        AM_LONG       = 5'd16,
        AM_LONG_X     = 5'd17,
        AM_REL8       = 5'd18,
        AM_REL16      = 5'd19
    } am_e;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_FIN} st_e;

    typedef enum logic {WRAP_PAGE, WRAP_BANK} wrap_e;

    typedef struct packed {
        am_e                 mode;
        logic                wr;
        logic                emu;
        logic                idx8;
        logic [WORD_W-1:0]   x;
        logic [WORD_W-1:0]   y;
        logic [WORD_W-1:0]   d;
        logic [WORD_W-1:0]   s;
        logic [WORD_W-1:0]   pc;
        logic [BANK_W-1:0]   db;
        logic [BANK_W-1:0]   pb;
        logic [ADDR_W-1:0]   opnd;
    } ctx_t;

    typedef struct packed {
        logic [BIDX_W-1:0]   nbytes;
        logic [WORD_W-1:0]   base;
        wrap_e               wrap;
        logic [BANK_W-1:0]   bank;
    } ptr_plan_t;

    // Address of pointer byte idx under the plan's wrap rule.
    function automatic logic [ADDR_W-1:0] ptr_byte_addr(ptr_plan_t p, logic [BIDX_W-1:0] idx);
        logic [WORD_W-1:0] off;
        logic [BANK_W-1:0] lo;
        lo  = p.base[BANK_W-1:0] + BANK_W'(idx);
        off = (p.wrap == WRAP_PAGE) ? {p.base[WORD_W-1:BANK_W], lo}
                                    : p.base + WORD_W'(idx);
        return {p.bank, off};
    endfunction

    // Direct page treated as a 256-byte page.
    function automatic logic dp_is_page(ctx_t c);
        return c.emu && (c.d[BANK_W-1:0] == '0);
    endfunction

    // Direct address indexed by one register under the page rule.
    function automatic logic [WORD_W-1:0] dp_indexed(ctx_t c, logic [WORD_W-1:0] idx);
        logic [WORD_W-1:0] dp;
        logic [BANK_W-1:0] lo;
        dp = c.d + {{BANK_W{1'b0}}, c.opnd[BANK_W-1:0]};
        lo = dp[BANK_W-1:0] + idx[BANK_W-1:0];
        return dp_is_page(c) ? {dp[WORD_W-1:BANK_W], lo} : dp + idx;
    endfunction

    // Indexed penalty: write, wide index, or low-byte carry.
    function automatic logic idx_penalty(logic [BANK_W-1:0] lo, logic [BANK_W-1:0] ilo,
                                         logic wr, logic idx8);
        logic [BANK_W:0] sum;
        sum = {1'b0, lo} + {1'b0, ilo};
        return wr || !idx8 || sum[BANK_W];
    endfunction

endpackage

// File: rtl/ea_ptr_plan.sv
module ea_ptr_plan
    import ea_pkg::*;
(
    input  ctx_t      c,
    output ptr_plan_t plan
);
    logic [WORD_W-1:0] dp_addr;
    logic [WORD_W-1:0] dpx_addr;
    logic [WORD_W-1:0] sr_addr;
    logic [WORD_W-1:0] op16;
    wrap_e             dp_wrap;
    logic              unused_ctx;

    assign op16     = c.opnd[WORD_W-1:0];
    assign dp_addr  = c.d + {{BANK_W{1'b0}}, c.opnd[BANK_W-1:0]};
    assign dpx_addr = dp_indexed(c, c.x);
    assign sr_addr  = c.s + {{BANK_W{1'b0}}, c.opnd[BANK_W-1:0]};
    assign dp_wrap  = dp_is_page(c) ? WRAP_PAGE : WRAP_BANK;
    assign unused_ctx = ^{c.y, c.pc, c.db, c.wr, c.idx8, c.opnd[ADDR_W-1:WORD_W]};

    always_comb begin
        plan = '{nbytes: '0, base: dp_addr, wrap: WRAP_BANK, bank: '0};
        unique case (c.mode)
            AM_DP_IND, AM_DP_IND_Y: begin
                plan.nbytes = BIDX_W'(2);
                plan.wrap   = dp_wrap;
            end
            AM_DP_X_IND: begin
                plan.nbytes = BIDX_W'(2);
                plan.base   = dpx_addr;
                plan.wrap   = dp_wrap;
            end
            AM_DP_LONG, AM_DP_LONG_Y: begin
                plan.nbytes = BIDX_W'(3);
            end
            AM_ABS_IND: begin
                plan.nbytes = BIDX_W'(2);
                plan.base   = op16;
            end
            AM_ABS_X_IND: begin
                plan.nbytes = BIDX_W'(2);
                plan.base   = op16 + c.x;
                plan.bank   = c.pb;
            end
            AM_ABS_LIND: begin
                plan.nbytes = BIDX_W'(3);
                plan.base   = op16;
            end
            AM_SR_IND_Y: begin
                plan.nbytes = BIDX_W'(2);
                plan.base   = sr_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ea_result.sv
module ea_result
    import ea_pkg::*;
(
    input  ctx_t                        c,
    input  logic [PTR_MAX*BANK_W-1:0]   ptr,
    output logic [ADDR_W-1:0]           ea,
    output logic [PEN_W-1:0]            extra
);
    logic [WORD_W-1:0] dp_addr;
    logic [WORD_W-1:0] sr_addr;
    logic [WORD_W-1:0] op16;
    logic [ADDR_W-1:0] abs_addr;
    logic [ADDR_W-1:0] ind_db;
    logic [ADDR_W-1:0] x24;
    logic [ADDR_W-1:0] y24;
    logic [PEN_W-1:0]  dpen;
    logic [WORD_W-1:0] rel8;

    assign op16     = c.opnd[WORD_W-1:0];
    assign dp_addr  = c.d + {{BANK_W{1'b0}}, c.opnd[BANK_W-1:0]};
    assign sr_addr  = c.s + {{BANK_W{1'b0}}, c.opnd[BANK_W-1:0]};
    assign abs_addr = {c.db, op16};
    assign ind_db   = {c.db, ptr[WORD_W-1:0]};
    assign x24      = {{BANK_W{1'b0}}, c.x};
    assign y24      = {{BANK_W{1'b0}}, c.y};
    assign dpen     = PEN_W'(c.d[BANK_W-1:0] != '0);
    assign rel8     = {{BANK_W{c.opnd[BANK_W-1]}}, c.opnd[BANK_W-1:0]};

    always_comb begin
        ea    = abs_addr;
        extra = '0;
        unique case (c.mode)
            AM_DP:        begin ea = {{BANK_W{1'b0}}, dp_addr}; extra = dpen; end
            AM_DP_X:      begin ea = {{BANK_W{1'b0}}, dp_indexed(c, c.x)}; extra = dpen + PEN_W'(1); end
            AM_DP_Y:      begin ea = {{BANK_W{1'b0}}, dp_indexed(c, c.y)}; extra = dpen + PEN_W'(1); end
            AM_DP_IND:    begin ea = ind_db; extra = dpen; end
            AM_DP_X_IND:  begin ea = ind_db; extra = dpen + PEN_W'(1); end
            AM_DP_IND_Y: begin
                ea    = ind_db + y24;
                extra = dpen + PEN_W'(idx_penalty(ptr[BANK_W-1:0], c.y[BANK_W-1:0], c.wr, c.idx8));
            end
            AM_DP_LONG:   begin ea = ptr; extra = dpen; end
            AM_DP_LONG_Y: begin ea = ptr + y24; extra = dpen; end
            AM_ABS:       ea = abs_addr;
            AM_ABS_X: begin
                ea    = abs_addr + x24;
                extra = PEN_W'(idx_penalty(op16[BANK_W-1:0], c.x[BANK_W-1:0], c.wr, c.idx8));
            end
            AM_ABS_Y: begin
                ea    = abs_addr + y24;
                extra = PEN_W'(idx_penalty(op16[BANK_W-1:0], c.y[BANK_W-1:0], c.wr, c.idx8));
            end
            AM_ABS_IND:   ea = {c.pb, ptr[WORD_W-1:0]};
            AM_ABS_X_IND: begin ea = {c.pb, ptr[WORD_W-1:0]}; extra = PEN_W'(1); end
            AM_ABS_LIND:  ea = ptr;
            AM_SR:        begin ea = {{BANK_W{1'b0}}, sr_addr}; extra = PEN_W'(1); end
            AM_SR_IND_Y:  begin ea = ind_db + y24; extra = PEN_W'(2); end
            AM_LONG:      ea = c.opnd;
            AM_LONG_X:    ea = c.opnd + x24;
            AM_REL8:      ea = {c.pb, c.pc + rel8};
            AM_REL16:     ea = {c.pb, c.pc + op16};
            default: ;
        endcase
    end
endmodule

// File: rtl/eff_addr_seq.sv
module eff_addr_seq
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [4:0]          mode,
    input  logic [23:0]         opnd,
    input  logic                is_write,
    input  logic                emu,
    input  logic                idx8,
    input  logic [15:0]         reg_x,
    input  logic [15:0]         reg_y,
    input  logic [15:0]         reg_d,
    input  logic [15:0]         reg_s,
    input  logic [15:0]         reg_pc,
    input  logic [7:0]          reg_db,
    input  logic [7:0]          reg_pb,
    output logic                mem_req,
    output logic [23:0]         mem_addr,
    input  logic                mem_valid,
    input  logic [7:0]          mem_rdata,
    output logic                done,
    output logic [23:0]         ea,
    output logic [1:0]          extra_cyc,
    output logic [7:0]          open_bus
);
    st_e                         state;
    ctx_t                        ctx_in, ctx_q, ctx_cur;
    ptr_plan_t                   plan;
    logic [PTR_MAX*BANK_W-1:0]   bytes_q;
    logic [BIDX_W-1:0]           bidx;
    logic [BANK_W-1:0]           obus_q;

    always_comb begin
        ctx_in.mode = am_e'(mode);
        ctx_in.wr   = is_write;
        ctx_in.emu  = emu;
        ctx_in.idx8 = idx8;
        ctx_in.x    = reg_x;
        ctx_in.y    = reg_y;
        ctx_in.d    = reg_d;
        ctx_in.s    = reg_s;
        ctx_in.pc   = reg_pc;
        ctx_in.db   = reg_db;
        ctx_in.pb   = reg_pb;
        ctx_in.opnd = opnd;
    end

    // In idle the plan looks at the live inputs to choose the first state.
    assign ctx_cur = (state == ST_IDLE) ? ctx_in : ctx_q;

    ea_ptr_plan u_plan (.c(ctx_cur), .plan(plan));
    ea_result   u_res  (.c(ctx_q), .ptr(bytes_q), .ea(ea), .extra(extra_cyc));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            ctx_q   <= '0;
            bytes_q <= '0;
            bidx    <= '0;
            obus_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ctx_q   <= ctx_in;
                    bytes_q <= '0;
                    bidx    <= '0;
                    state   <= (plan.nbytes == '0) ? ST_FIN : ST_REQ;
                end
                ST_REQ:  state <= ST_WAIT;
                ST_WAIT: if (mem_valid) begin
                    unique case (bidx)
                        BIDX_W'(0): bytes_q[7:0]   <= mem_rdata;
                        BIDX_W'(1): bytes_q[15:8]  <= mem_rdata;
                        default:    bytes_q[23:16] <= mem_rdata;
                    endcase
                    if (!ctx_q.wr) obus_q <= mem_rdata;
                    if (bidx == plan.nbytes - BIDX_W'(1)) begin
                        state <= ST_FIN;
                    end else begin
                        bidx  <= bidx + BIDX_W'(1);
                        state <= ST_REQ;
                    end
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req  = (state == ST_REQ);
    assign mem_addr = ptr_byte_addr(plan, bidx);
    assign done     = (state == ST_FIN);
    assign open_bus = obus_q;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R12
    AST_REQ_SINGLE:  assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R12
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (rst) done |-> !mem_req); // R12
    AST_EXTRA_LIMIT: assert property (@(posedge clk) disable iff (rst) done |-> (extra_cyc <= 2'd2)); // R8
    AST_OBUS_IDLE:   assert property (@(posedge clk) disable iff (rst) (!mem_valid && !mem_req) |=> $stable(open_bus)); // R11
    AST_BANK0_FETCH: assert property (@(posedge clk) disable iff (rst)
        (mem_req && ctx_q.mode != AM_ABS_X_IND) |-> (mem_addr[23:16] == 8'h00)); // R3
endmodule

// File: tb/sim_eff_addr_seq.sv
module sim_eff_addr_seq;
    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [4:0] mode = '0;
    logic [23:0] opnd = '0;
    logic is_write = 1'b0, emu = 1'b0, idx8 = 1'b0;
    logic [15:0] reg_x = '0, reg_y = '0, reg_d = '0, reg_s = '0, reg_pc = '0;
    logic [7:0] reg_db = '0, reg_pb = '0;
    logic mem_req, mem_valid = 1'b0, done;
    logic [23:0] mem_addr, ea;
    logic [7:0] mem_rdata = '0, open_bus;
    logic [1:0] extra_cyc;

    int n_cmp = 0, n_bad = 0;
    logic log_clr = 1'b0;
    int log_cnt = 0;
    logic [23:0] log_addr [0:7];

    int e_ea, e_ext, e_n, e_obus;
    int e_f [0:2];

    always #5 clk = ~clk;

    eff_addr_seq u0 (.*);

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h3C);
    endfunction

    // Memory: answers each request one cycle later and logs the address.
    always @(posedge clk) begin
        mem_valid <= mem_req;
        if (mem_req) mem_rdata <= memf(mem_addr);
        if (log_clr) log_cnt <= 0;
        else if (mem_req) begin
            if (log_cnt < 8) log_addr[log_cnt] <= mem_addr;
            log_cnt <= log_cnt + 1;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s mode=%0d actual=%h expected=%h", req, what, mode, act, exp);
        end
    endtask

    function automatic string req_of(input int m);
        case (m)
            0: return "R1";
            1, 2: return "R2";
            3, 4: return "R3";
            5: return "R4";
            8, 9, 10: return "R5";
            11, 12: return "R6";
            6, 7, 13: return "R7";
            14, 15: return "R8";
            16, 17: return "R9";
            default: return "R10";
        endcase
    endfunction

    // Reference: computes fetch addresses, expected address and penalty.
    task automatic model();
        int m, dp, pg, dl, o0, o16, o24, base, bank, pw, ptr, pen_ix, off;
        int b [0:2];
        m = mode; o0 = opnd[7:0]; o16 = opnd[15:0]; o24 = opnd;
        dp = (reg_d + o0) % 65536;
        pg = (emu && reg_d[7:0] == 0);
        dl = (reg_d[7:0] != 0) ? 1 : 0;
        e_n = 0; base = 0; bank = 0; pw = 0;
        case (m)
            3, 5: begin e_n = 2; base = dp; pw = pg; end
            4: begin
                e_n = 2; pw = pg;
                base = pg ? ((dp & 'hFF00) | ((dp + reg_x) & 'hFF)) : (dp + reg_x) % 65536;
            end
            6, 7: begin e_n = 3; base = dp; end
            11: begin e_n = 2; base = o16; end
            12: begin e_n = 2; base = (o16 + reg_x) % 65536; bank = reg_pb; end
            13: begin e_n = 3; base = o16; end
            15: begin e_n = 2; base = (reg_s + o0) % 65536; end
            default: ;
        endcase
        for (int i = 0; i < 3; i++) begin
            e_f[i] = bank * 65536 + (pw ? ((base & 'hFF00) | ((base + i) & 'hFF)) : (base + i) % 65536);
            b[i] = (i < e_n) ? memf(e_f[i][23:0]) : 0;
        end
        ptr = b[0] + 256 * b[1] + 65536 * b[2];
        if (e_n > 0 && !is_write) e_obus = b[e_n - 1];
        e_ext = 0;
        case (m)
            0: begin e_ea = dp; e_ext = dl; end
            1, 2: begin
                off = (m == 1) ? reg_x : reg_y;
                e_ea = pg ? ((dp & 'hFF00) | ((dp + off) & 'hFF)) : (dp + off) % 65536;
                e_ext = dl + 1;
            end
            3: begin e_ea = reg_db * 65536 + ptr; e_ext = dl; end
            4: begin e_ea = reg_db * 65536 + ptr; e_ext = dl + 1; end
            5: begin
                e_ea = (reg_db * 65536 + ptr + reg_y) % 16777216;
                pen_ix = (is_write || !idx8 || (b[0] + reg_y[7:0]) >= 256) ? 1 : 0;
                e_ext = dl + pen_ix;
            end
            6: begin e_ea = ptr; e_ext = dl; end
            7: begin e_ea = (ptr + reg_y) % 16777216; e_ext = dl; end
            8: e_ea = reg_db * 65536 + o16;
            9, 10: begin
                off = (m == 9) ? reg_x : reg_y;
                e_ea = (reg_db * 65536 + o16 + off) % 16777216;
                e_ext = (is_write || !idx8 || (o0 + (off % 256)) >= 256) ? 1 : 0;
            end
            11: e_ea = reg_pb * 65536 + ptr;
            12: begin e_ea = reg_pb * 65536 + ptr; e_ext = 1; end
            13: e_ea = ptr;
            14: begin e_ea = (reg_s + o0) % 65536; e_ext = 1; end
            15: begin e_ea = (reg_db * 65536 + ptr + reg_y) % 16777216; e_ext = 2; end
            16: e_ea = o24;
            17: e_ea = (o24 + reg_x) % 16777216;
            18: begin
                off = (o0 >= 128) ? o0 - 256 : o0;
                e_ea = reg_pb * 65536 + (reg_pc + off + 65536) % 65536;
            end
            default: e_ea = reg_pb * 65536 + (reg_pc + o16) % 65536;
        endcase
    endtask

    task automatic load_set(input int p);
        case (p)
            0: begin reg_d='h0000; reg_x='h0003; reg_y='h0004; reg_s='h01F0; opnd='h123456; reg_db='h7E; reg_pb='h80; reg_pc='h8000; end
            1: begin reg_d='h1234; reg_x='h00FF; reg_y='hFF80; reg_s='h1FFF; opnd='hFFFFFF; reg_db='hFF; reg_pb='h00; reg_pc='hFFFF; end
            2: begin reg_d='hFF00; reg_x='hFFFF; reg_y='h0001; reg_s='hFFFE; opnd='h00FFFF; reg_db='h01; reg_pb='h7F; reg_pc='h0000; end
            3: begin reg_d='h0100; reg_x='h0080; reg_y='h0080; reg_s='h0100; opnd='h8081FE; reg_db='h00; reg_pb='hC0; reg_pc='h1234; end
            4: begin reg_d='hFFFF; reg_x='h0000; reg_y='h0000; reg_s='h0000; opnd='h000180; reg_db='h12; reg_pb='h34; reg_pc='h0005; end
            5: begin reg_d='h0000; reg_x='h00FF; reg_y='h00FF; reg_s='hFF00; opnd='h7F00FF; reg_db='h80; reg_pb='hFF; reg_pc='hFFF0; end
            6: begin reg_d='h8001; reg_x='h1234; reg_y='h5678; reg_s='h00FF; opnd='h0AFFFF; reg_db='hA5; reg_pb='h5A; reg_pc='h4000; end
            default: begin reg_d='h0000; reg_x='h0001; reg_y='h0001; reg_s='h0000; opnd='h00FF01; reg_db='h3C; reg_pb='h01; reg_pc='h7FFF; end
        endcase
    endtask

    task automatic run_one(input int m, input int p, input bit w, input bit ix, input bit em);
        int seen;
        string rq;
        rq = req_of(m);
        @(negedge clk);
        mode = 5'(m); is_write = w; idx8 = ix; emu = em;
        load_set(p);
        model();
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        start = 1'b1;
        seen = 0;
        for (int cyc = 0; cyc < 20 && seen == 0; cyc++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                check(rq, "ea", ea, e_ea);
                check(rq, "extra", extra_cyc, e_ext);
                check("R11", "open_bus", open_bus, e_obus);
                check("R12", "req count", log_cnt, e_n);
                for (int i = 0; i < 3; i++)
                    if (i < e_n) check("R12", "fetch addr", log_addr[i], e_f[i]);
            end
            // Second start with scrambled inputs while busy must be ignored (R12).
            if (cyc == 0) begin
                start = 1'b1;
                mode = 5'((m + 7) % 20);
                reg_x = ~reg_x; reg_y = reg_y + 16'h1111; reg_d = ~reg_d;
                reg_db = ~reg_db; opnd = ~opnd; is_write = ~is_write;
            end else begin
                start = 1'b0;
            end
        end
        check("R12", "done seen", seen, 1);
        start = 1'b0;
        @(negedge clk);
        check("R12", "done single", done, 0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        e_obus = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R13", "done after reset", done, 0);
        check("R13", "mem_req after reset", mem_req, 0);
        check("R13", "open_bus after reset", open_bus, 0);
        for (int m = 0; m < 20; m++)
            for (int p = 0; p < 8; p++)
                for (int k = 0; k < 8; k++)
                    run_one(m, p, k[0], k[1], k[2]);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule